// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block sits between two 16-bit data ports, A and B. Each direction of flow owns a separate storage latch and three active-low controls: a chip enable, a latch enable and an output enable. The A-to-B latch takes its data from port A and can drive port B. The B-to-A latch takes its data from port B and can drive port A. A direction's latch is transparent only while its chip enable and latch enable are both low. The stored word reaches the far port only while that direction's chip enable and output enable are both low.

The word is split into two 8-bit lanes, and each lane has its own full set of six controls. A mode input ties both lanes to lane 0's controls so that the block acts as one 16-bit unit. Each port is modelled as three signals: an input value, a per-bit "externally driven" flag, and a per-bit output value with an output-enable. Bus resolution happens outside the block.

A floating input bit keeps the last level an external driver put on it (bus hold). All outputs are released while the power-good input is low, and they stay released until power has been good for a set number of clocks. The clock is used only by the bus-hold registers, the power-up counter and the reset of the latches.

Top module: `xcvr_latched_bidir`

## Requirements
- R1: With a lane's A-to-B chip enable and latch enable both low, that lane's A-to-B latch follows the A-side input level.
- R2: When the A-to-B latch enable rises, or the chip enable rises while the latch enable is low, the latch keeps its value. Later changes on A then have no effect on it.
- R3: B bits of a lane are driven (b_oe=1, b_out=latch) only while that lane's A-to-B chip enable and output enable are both low and power is ready. Otherwise b_oe=0 and b_out=0.
- R4: The B-to-A direction behaves as in R1 to R3, using its own three controls, port B as source and port A as destination.
- R5: With wide_mode=0, lane k's controls govern bits [8k+7:8k] only. With wide_mode=1, lane 0's controls govern all bits and the lane 1 controls are ignored.
- R6: An input bit whose drive flag is 0 presents the level it was sampled at on the last clock edge where its drive flag was 1.
- R7: While pwr_good is low, every oe bit is 0 whatever the controls. Output drive is allowed only after pwr_good has been high for PWRUP_CYCLES (default 4) consecutive clock edges with rst_n high.
- R8: A reset (rst_n low at a clock edge) clears both latches and both bus-hold registers to zero.
- R9: With both directions transparent and driving at the same time, each latch takes the external or held level of its source port and never the opposite direction's drive, so the values stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus hold, power-up counting and reset |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good; low forces all outputs released |
| wide_mode | input | 1 | 1: lane 0 controls govern the whole word |
| ceab_n | input | 2 | A-to-B chip enable per lane, active low |
| leab_n | input | 2 | A-to-B latch enable per lane, active low |
| oeab_n | input | 2 | A-to-B output enable per lane, active low |
| ceba_n | input | 2 | B-to-A chip enable per lane, active low |
| leba_n | input | 2 | B-to-A latch enable per lane, active low |
| oeba_n | input | 2 | B-to-A output enable per lane, active low |
| a_in | input | 16 | Level applied to port A by an external driver |
| a_drv | input | 16 | Per bit: 1 when an external driver is on port A |
| a_out | output | 16 | Value this block drives onto port A |
| a_oe | output | 16 | Per bit enable for a_out |
| b_in | input | 16 | Level applied to port B by an external driver |
| b_drv | input | 16 | Per bit: 1 when an external driver is on port B |
| b_out | output | 16 | Value this block drives onto port B |
| b_oe | output | 16 | Per bit enable for b_out |

## Verification
The hardest situation to reach is a latch that captured a bus-held level rather than a driven one. That needs a value driven across a clock edge, the driver then released, and only afterwards a latch opened. Random stimulus rarely lines these up, so directed sequences set this up for both ports. They also cover a store started by the chip enable rather than the latch enable, and both directions driving at once. Random steps then mix drive flags, lane controls, mode and occasional power drops against a reference model kept in the bench.

// File: rtl/xcvr_pkg.sv
// Shared types for the latched bidirectional transceiver.
// Assumes all controls are active low.
package xcvr_pkg;

    // One direction's control triple for one lane.
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctl_t;

endpackage

// File: rtl/xcvr_bus_hold.sv
// Bus-hold model for one port. A bit flagged as externally driven passes its
// input level through. A floating bit presents the level captured at the
// last clock edge where it was driven. The block's own drive onto the port is
// not seen here, so a latch never loops back on the opposite direction.
// Assumes inputs change away from the rising clock edge.
module xcvr_bus_hold #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pin_drv,
    output logic [WIDTH-1:0] level
);

    logic [WIDTH-1:0] held;

    // Per-bit choice between the live driven level and the held level.
    always_comb begin
        level = (pin_drv & pin_in) | (~pin_drv & held);
    end

    // Keeper register: follows the effective level, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            held <= level;
        end
    end

    // A bit that floated through the last cycle keeps its held value.
    assert_float_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((held ^ $past(held)) & ~$past(pin_drv)) == '0);

    // After a reset edge the keeper is empty.
    assert_hold_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> held == '0);

endmodule

// File: rtl/xcvr_pwr_seq.sv
// Power-up sequencing. Counts consecutive clock edges with supply good and
// reset released, and reports ready once PWRUP_CYCLES have passed. Any low
// on pwr_good removes ready at once and restarts the count.
module xcvr_pwr_seq #(
    parameter int PWRUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic ready
);

    localparam int CW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PWRUP_CYCLES);

    logic [CW-1:0] cnt;

    // Saturating count of good-supply cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Ready needs the supply good right now and the count complete.
    always_comb begin
        ready = pwr_good && (cnt == LIMIT);
    end

    // A supply dip in the last cycle means drive is not yet allowed.
    assert_no_early_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_good) |-> !ready);

    // The counter never passes its limit.
    assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

endmodule

// File: rtl/xcvr_dir_latch.sv
// One lane of one direction: a level-sensitive storage latch and its
// output-drive gate. The latch is open while chip enable and latch enable
// are both low. It is cleared while clr is high. The output is driven while
// chip enable and output enable are low and power is ready; otherwise the
// value and enable are both zero.
module xcvr_dir_latch
    import xcvr_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ready,
    input  dir_ctl_t      ctl,
    input  logic [LW-1:0] d,
    output logic [LW-1:0] q_out,
    output logic [LW-1:0] q_oe
);

    logic          open;
    logic          drive;
    logic [LW-1:0] q;

    // Decode of the active-low control triple.
    always_comb begin
        open  = !ctl.ce_n && !ctl.le_n;
        drive = ready && !ctl.ce_n && !ctl.oe_n;
    end

    // Storage latch: clear wins, otherwise transparent while open.
    always_latch begin
        if (clr) begin
            q <= '0;
        end else if (open) begin
            q <= d;
        end
    end

    // Gated drive onto the destination port.
    always_comb begin
        q_oe  = {LW{drive}};
        q_out = drive ? q : '0;
    end

    // An open latch shows its source level.
    assert_open_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !clr) |-> q == d);

    // A latch closed for a whole cycle does not move.
    assert_closed_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && $past(!open) && !clr && !$past(clr)) |-> $stable(q));

endmodule

// File: rtl/xcvr_latched_bidir.sv
// Latched bidirectional transceiver, top level. Each lane has an A-to-B and a
// B-to-A latch with their own controls. In wide mode lane 0's controls steer
// every lane. Each latch reads its source port through bus hold, which does
// not see the block's own drive. This keeps the two directions free of any
// combinational loop when both drive at once. Assumes inputs change away
// from the rising clock edge.
module xcvr_latched_bidir
    import xcvr_pkg::*;
#(
    parameter int LANE_W       = 8,
    parameter int LANES        = 2,
    parameter int PWRUP_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_good,
    input  logic                      wide_mode,
    input  logic [LANES-1:0]          ceab_n,
    input  logic [LANES-1:0]          leab_n,
    input  logic [LANES-1:0]          oeab_n,
    input  logic [LANES-1:0]          ceba_n,
    input  logic [LANES-1:0]          leba_n,
    input  logic [LANES-1:0]          oeba_n,
    input  logic [LANES*LANE_W-1:0]   a_in,
    input  logic [LANES*LANE_W-1:0]   a_drv,
    output logic [LANES*LANE_W-1:0]   a_out,
    output logic [LANES*LANE_W-1:0]   a_oe,
    input  logic [LANES*LANE_W-1:0]   b_in,
    input  logic [LANES*LANE_W-1:0]   b_drv,
    output logic [LANES*LANE_W-1:0]   b_out,
    output logic [LANES*LANE_W-1:0]   b_oe
);

    localparam int WIDTH = LANES * LANE_W;

    logic             clr_q;
    logic             ready;
    logic [WIDTH-1:0] a_level;
    logic [WIDTH-1:0] b_level;

    // Registered reset used to clear the latches synchronously.
    always_ff @(posedge clk) begin
        clr_q <= !rst_n;
    end

    xcvr_pwr_seq #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .ready    (ready)
    );

    xcvr_bus_hold #(.WIDTH(WIDTH)) u_hold_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (a_in),
        .pin_drv (a_drv),
        .level   (a_level)
    );

    xcvr_bus_hold #(.WIDTH(WIDTH)) u_hold_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (b_in),
        .pin_drv (b_drv),
        .level   (b_level)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = k * LANE_W;

        dir_ctl_t ab_ctl;
        dir_ctl_t ba_ctl;

        // Control selection: wide mode borrows lane 0's controls.
        always_comb begin
            if (wide_mode) begin
                ab_ctl = '{ce_n: ceab_n[0], le_n: leab_n[0], oe_n: oeab_n[0]};
                ba_ctl = '{ce_n: ceba_n[0], le_n: leba_n[0], oe_n: oeba_n[0]};
            end else begin
                ab_ctl = '{ce_n: ceab_n[k], le_n: leab_n[k], oe_n: oeab_n[k]};
                ba_ctl = '{ce_n: ceba_n[k], le_n: leba_n[k], oe_n: oeba_n[k]};
            end
        end

        xcvr_dir_latch #(.LW(LANE_W)) u_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_q),
            .ready (ready),
            .ctl   (ab_ctl),
            .d     (a_level[LO +: LANE_W]),
            .q_out (b_out[LO +: LANE_W]),
            .q_oe  (b_oe[LO +: LANE_W])
        );

        xcvr_dir_latch #(.LW(LANE_W)) u_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_q),
            .ready (ready),
            .ctl   (ba_ctl),
            .d     (b_level[LO +: LANE_W]),
            .q_out (a_out[LO +: LANE_W]),
            .q_oe  (a_oe[LO +: LANE_W])
        );
    end

    // No output drives while the supply is not good.
    assert_unpowered_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (a_oe == '0 && b_oe == '0));

    // A released port bit carries a zero value.
    assert_released_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_out & ~b_oe) == '0) && ((a_out & ~a_oe) == '0));

endmodule

// File: tb/tb_xcvr_latched_bidir.sv
`timescale 1ns/1ps
module tb_xcvr_latched_bidir;

    localparam int LW = 8;
    localparam int L  = 2;
    localparam int W  = LW * L;
    localparam int N  = 4;

    logic         clk = 1'b0;
    logic         rst_n, pwr_good, wide_mode;
    logic [L-1:0] ceab_n, leab_n, oeab_n, ceba_n, leba_n, oeba_n;
    logic [W-1:0] a_in, a_drv, b_in, b_drv;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    logic [W-1:0] hold_a = '0, hold_b = '0, lat_ab = '0, lat_ba = '0;
    logic [W-1:0] ext_a, ext_b;
    logic         clr_m = 1'b1;
    int           cnt_m = 0;

    always #2 clk = ~clk;

    xcvr_latched_bidir #(.LANE_W(LW), .LANES(L), .PWRUP_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wide_mode(wide_mode),
        .ceab_n(ceab_n), .leab_n(leab_n), .oeab_n(oeab_n),
        .ceba_n(ceba_n), .leba_n(leba_n), .oeba_n(oeba_n),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe));

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply the model to the current inputs and compare every output.
    task automatic eval_and_check(string tag, bit do_chk);
        logic [W-1:0] eb_out, eb_oe, ea_out, ea_oe;
        bit ready_m;
        ext_a = (a_drv & a_in) | (~a_drv & hold_a);
        ext_b = (b_drv & b_in) | (~b_drv & hold_b);
        ready_m = pwr_good && (cnt_m == N);
        for (int k = 0; k < L; k++) begin
            int c = wide_mode ? 0 : k;
            bit ab_open = !ceab_n[c] && !leab_n[c];
            bit ba_open = !ceba_n[c] && !leba_n[c];
            bit ab_drv  = ready_m && !ceab_n[c] && !oeab_n[c];
            bit ba_drv  = ready_m && !ceba_n[c] && !oeba_n[c];
            if (clr_m) begin
                lat_ab[k*LW +: LW] = '0;
                lat_ba[k*LW +: LW] = '0;
            end else begin
                if (ab_open) lat_ab[k*LW +: LW] = ext_a[k*LW +: LW];
                if (ba_open) lat_ba[k*LW +: LW] = ext_b[k*LW +: LW];
            end
            eb_oe[k*LW +: LW]  = {LW{ab_drv}};
            eb_out[k*LW +: LW] = ab_drv ? lat_ab[k*LW +: LW] : '0;
            ea_oe[k*LW +: LW]  = {LW{ba_drv}};
            ea_out[k*LW +: LW] = ba_drv ? lat_ba[k*LW +: LW] : '0;
        end
        if (do_chk) begin
            check(tag, "b_oe", b_oe, eb_oe);
            check(tag, "b_out", b_out, eb_out);
            check(tag, "a_oe", a_oe, ea_oe);
            check(tag, "a_out", a_out, ea_out);
        end
    endtask

    // One cycle: called at a falling edge after inputs are set, returns at the next.
    task automatic step(string tag, bit do_chk = 1'b1);
        #1;
        eval_and_check(tag, do_chk);
        @(posedge clk);
        hold_a = rst_n ? ext_a : '0;
        hold_b = rst_n ? ext_b : '0;
        clr_m  = !rst_n;
        if (!rst_n || !pwr_good) cnt_m = 0;
        else if (cnt_m != N) cnt_m = cnt_m + 1;
        @(negedge clk);
    endtask

    task automatic idle_ctl();
        ceab_n = '1; leab_n = '1; oeab_n = '1;
        ceba_n = '1; leba_n = '1; oeba_n = '1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; pwr_good = 1'b1; wide_mode = 1'b0;
        idle_ctl();
        a_in = '0; a_drv = '0; b_in = '0; b_drv = '0;
        @(negedge clk);
        step("reset", 1'b0);
        step("reset", 1'b0);
        // R8: reset state with outputs released.
        step("R8 reset");
        rst_n = 1'b1;
        // R7: drive requested but power count not complete.
        ceab_n = '0; oeab_n = '0; ceba_n = '0; oeba_n = '0;
        for (int i = 0; i < N + 2; i++) step("R7 power-up count");
        // R8 and R6: open latches on floating ports read cleared keepers.
        leab_n = '0; leba_n = '0;
        step("R8 cleared latch");
        step("R6 cleared hold");
        leab_n = '1; leba_n = '1;
        // R1: transparent path follows A.
        a_drv = '1; a_in = 16'hA5C3; leab_n = '0;
        step("R1 transparent");
        a_in = 16'h1234;
        step("R1 follow");
        // R2: latch enable rise stores, A changes ignored.
        leab_n = '1;
        step("R2 le store");
        a_in = 16'hFFFF;
        step("R2 le ignore");
        step("R2 le ignore");
        // R2: chip enable rise with latch enable low stores.
        leab_n = '0; a_in = 16'h5555;
        step("R2 ce open");
        ceab_n = '1;
        step("R2 ce store");
        a_in = 16'h0F0F;
        step("R2 ce ignore");
        leab_n = '1; ceab_n = '0;
        step("R2 ce readback");
        // R3: output enable high releases B.
        oeab_n = '1;
        step("R3 oe high");
        oeab_n = 2'b10;
        step("R3 lane oe");
        oeab_n = '0;
        // R4: B-to-A direction.
        a_drv = '0; b_drv = '1; b_in = 16'h3C96; leba_n = '0;
        step("R4 transparent");
        leba_n = '1; b_in = 16'h0001;
        step("R4 store");
        oeba_n = '1;
        step("R4 oe high");
        oeba_n = '0;
        // R5: per-lane control, then wide mode.
        b_drv = '0; a_drv = '1; a_in = 16'hC0DE; leab_n = 2'b10;
        step("R5 lane0 only");
        leab_n = 2'b01; a_in = 16'hBEAD;
        step("R5 lane1 only");
        wide_mode = 1'b1; leab_n = 2'b01; a_in = 16'h7E57; oeab_n = 2'b10;
        step("R5 wide");
        leab_n = 2'b10; a_in = 16'h1111;
        step("R5 wide lane1 ignored");
        wide_mode = 1'b0; leab_n = '1; oeab_n = '0;
        // R6: drive, float, then open latch.
        a_in = 16'hBEEF; a_drv = '1;
        step("R6 drive");
        a_drv = '0; a_in = 16'h0000;
        step("R6 float");
        leab_n = '0;
        step("R6 held capture");
        leab_n = '1;
        b_drv = 16'h00FF; b_in = 16'h1357;
        step("R6 b drive");
        b_drv = '0; b_in = '1; leba_n = '0;
        step("R6 b partial hold");
        // R9: both directions transparent and driving together.
        a_drv = '1; b_drv = '1; a_in = 16'h2468; b_in = 16'h9BDF;
        leab_n = '0; leba_n = '0; ceab_n = '0; ceba_n = '0; oeab_n = '0; oeba_n = '0;
        step("R9 both open");
        a_drv = '0; b_drv = '0;
        for (int i = 0; i < 4; i++) step("R9 no race");
        // R7: supply dip releases outputs, then recount.
        pwr_good = 1'b0;
        step("R7 dip");
        pwr_good = 1'b1;
        for (int i = 0; i < N + 1; i++) step("R7 recount");
        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            ceab_n = 2'($urandom); leab_n = 2'($urandom); oeab_n = 2'($urandom);
            ceba_n = 2'($urandom); leba_n = 2'($urandom); oeba_n = 2'($urandom);
            wide_mode = (r[3:0] == 4'h0);
            pwr_good  = (r[9:4] != 6'h0);
            a_in = 16'($urandom); b_in = 16'($urandom);
            a_drv = 16'($urandom); b_drv = 16'($urandom);
            if (r[12]) a_drv = '0;
            if (r[13]) b_drv = '0;
            rst_n = (r[31:22] != 10'h0);
            step("random", rst_n);
            rst_n = 1'b1;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule